// File: doc/BRIEF.md
# Event Timer Register File with Main Counter

This block is the software-visible register file of a multi-channel event timer. It keeps a free-running 64-bit main counter, a read-only capability word pair, a two-bit global control word, and one register bank per timer channel, all reached through a 32-bit single-cycle read/write port that decodes a 1 KiB window. Read data is returned combinationally for the word address on the bus. Comparator arithmetic and interrupt routing live elsewhere. This block only hands them per-channel write strobes, a word index, a one-cycle re-arm pulse and the live counter value.

The counter advances by one per clock while the global enable bit is set. It holds its value while that bit is clear. Software can overwrite either 32-bit half of it at any moment. When the enable bit goes from clear to set, every channel whose comparator is not all ones receives a re-arm pulse.

Top module: `evt_regfile`

## Requirements
- R1: After reset the counter and the global control word read zero. Every channel's configuration low word reads 0x30 (periodic-capable bit 4, 64-bit-capable bit 5, plus bit 15 only when MSG_CAP is set). Its configuration high word reads 0x4. Its comparator words read 0xFFFFFFFF. Its route words read zero.
- R2: Byte offset 0x000 reads 0x8086A001 with N-1 in bits 12:8, which is 0x8086A201 for N=3. Offset 0x004 reads the tick period in femtoseconds, 10,000,000 (0x00989680). Writes to these offsets have no effect.
- R3: The global control word at offset 0x010 keeps only written bits 1:0 (bit 0 = enable, bit 1 = legacy routing). Its high word at 0x014 always reads zero.
- R4: A write to a channel configuration low word (bank offset +0x00) changes only the bits under mask 0x7F4E. A write to the high word (+0x04) is ignored.
- R5: While enable is set, the counter grows by exactly one per clock, carrying from the low half into the high half.
- R6: Clearing enable freezes the counter. Setting it again resumes from the frozen value, with the first increment one clock after the enabling write.
- R7: Writes to offset 0x0F0 (low half) or 0x0F4 (high half) replace only that half, whether or not the counter runs. A half write takes precedence over the increment in the same clock.
- R8: In the clock after a write sets enable from clear, tmr_rearm is high for exactly one cycle for each channel whose comparator is not all ones, and low for the others.
- R9: Channel banks start at offset 0x100 with a 0x20 stride. A bank index at or beyond N produces no strobe, changes no state and reads zero.
- R10: Offsets with no register behind them (such as 0x008, 0x020, 0x0F8, bank +0x18) read zero.
- R11: Comparator (+0x08/+0x0C) and route (+0x10/+0x14) words read back what was last written. Any in-range bank write raises tmr_wstb for that channel alone, with tmr_woff equal to the word index within the bank (byte offset / 4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_waddr | input | 8 | Word address in the 1 KiB window (byte offset / 4) |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_waddr |
| tmr_wstb | output | N | Per-channel write strobe |
| tmr_woff | output | 3 | Word index within the addressed bank |
| tmr_rearm | output | N | One-cycle re-arm pulse per channel |
| glb_en | output | 1 | Global enable state |
| count | output | 64 | Main counter value |

## Verification
The bench checks the counter carry across the 32-bit boundary. A design that kept the halves apart would wrap the low word and leave the high word at zero. It also checks the clock on which enable and disable take effect. An off-by-one there would either skip the first increment or let the counter creep after disable. Half writes made while the counter runs must keep the untouched half and continue from the new value. Accesses to bank index N must neither strobe nor alias onto channel 0. Random configuration writes hit the protected capability bits, where a wrong mask would let software clear the periodic or 64-bit capability bit.

// File: rtl/evt_pkg.sv
package evt_pkg;

   // Word addresses (byte offset / 4) of the global registers
   localparam logic [7:0] WA_CAP_LO  = 8'h00;
   localparam logic [7:0] WA_CAP_HI  = 8'h01;
   localparam logic [7:0] WA_GCTL_LO = 8'h04;
   localparam logic [7:0] WA_GCTL_HI = 8'h05;
   localparam logic [7:0] WA_CNT_LO  = 8'h3C;
   localparam logic [7:0] WA_CNT_HI  = 8'h3D;

   // First bank sits at byte 0x100: bank field (word addr [7:3]) value 8
   localparam logic [4:0] BANK_FIRST = 5'd8;
   localparam int         MAX_BANKS  = 24;

   localparam logic [31:0] CAP_BASE   = 32'h8086_A001;
   localparam logic [31:0] TICK_FS    = 32'd10_000_000;
   localparam logic [31:0] TCFG_WMASK = 32'h0000_7F4E;
   localparam logic [31:0] TCFG_RST   = 32'h0000_0030;
   localparam logic [31:0] TCFG_MSGC  = 32'h0000_8000;
   localparam logic [31:0] TCFG_HI    = 32'h0000_0004;

   typedef enum logic [2:0] {
      BW_CFG_LO = 3'd0,
      BW_CFG_HI = 3'd1,
      BW_CMP_LO = 3'd2,
      BW_CMP_HI = 3'd3,
      BW_RTE_LO = 3'd4,
      BW_RTE_HI = 3'd5
   } bank_word_e;

endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
   parameter int W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         wr_lo,
   input  logic         wr_hi,
   input  logic [W/2-1:0] wdata,
   output logic [W-1:0] cnt
);
   localparam int HALF = W / 2;

   logic [W-1:0] nxt;

   always_comb begin
      nxt = run ? cnt + W'(1) : cnt;
      if (wr_lo) nxt[HALF-1:0] = wdata;
      if (wr_hi) nxt[W-1:HALF] = wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= nxt;
   end
endmodule

// File: rtl/evt_timer_bank.sv
module evt_timer_bank
   import evt_pkg::*;
#(
   parameter bit MSG_CAP = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wstb,
   input  logic [2:0]  woff,
   input  logic [31:0] wdata,
   output logic [31:0] rword,
   output logic        cmp_ones
);
   localparam logic [31:0] CFG_RST = MSG_CAP ? (TCFG_RST | TCFG_MSGC) : TCFG_RST;

   logic [31:0] cfg_lo;
   logic [63:0] cmp;
   logic [63:0] rte;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_lo <= CFG_RST;
         cmp    <= '1;
         rte    <= '0;
      end else if (wstb) begin
         case (woff)
            BW_CFG_LO: cfg_lo <= (cfg_lo & ~TCFG_WMASK) | (wdata & TCFG_WMASK);
            BW_CMP_LO: cmp[31:0]  <= wdata;
            BW_CMP_HI: cmp[63:32] <= wdata;
            BW_RTE_LO: rte[31:0]  <= wdata;
            BW_RTE_HI: rte[63:32] <= wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (woff)
         BW_CFG_LO: rword = cfg_lo;
         BW_CFG_HI: rword = TCFG_HI;
         BW_CMP_LO: rword = cmp[31:0];
         BW_CMP_HI: rword = cmp[63:32];
         BW_RTE_LO: rword = rte[31:0];
         BW_RTE_HI: rword = rte[63:32];
         default:   rword = '0;
      endcase
   end

   assign cmp_ones = &cmp;
endmodule

// File: rtl/evt_regfile.sv
module evt_regfile
   import evt_pkg::*;
#(
   parameter int N       = 3,
   parameter bit MSG_CAP = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [7:0]    bus_waddr,
   input  logic          bus_wr,
   input  logic [31:0]   bus_wdata,
   output logic [31:0]   bus_rdata,
   output logic [N-1:0]  tmr_wstb,
   output logic [2:0]    tmr_woff,
   output logic [N-1:0]  tmr_rearm,
   output logic          glb_en,
   output logic [63:0]   count
);
   localparam logic [31:0] CAP_LO = CAP_BASE | (32'(N - 1) << 8);

   generate
      if (N < 3 || N > MAX_BANKS) begin : g_bad_n
         $error("evt_regfile: N must lie in 3..24");
      end
   endgenerate

   logic [1:0]   gctl;
   logic         in_bank;
   logic [4:0]   bank_idx;
   logic [N-1:0] cmp_ones;
   logic [31:0]  bank_rd [N];

   assign in_bank  = (bus_waddr[7:6] != 2'b00);
   assign bank_idx = bus_waddr[7:3] - BANK_FIRST;
   assign tmr_woff = bus_waddr[2:0];
   assign glb_en   = gctl[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gctl      <= '0;
         tmr_rearm <= '0;
      end else begin
         tmr_rearm <= '0;
         if (bus_wr && bus_waddr == WA_GCTL_LO) begin
            gctl <= bus_wdata[1:0];
            if (bus_wdata[0] && !gctl[0]) tmr_rearm <= ~cmp_ones;
         end
      end
   end

   evt_counter #(.W(64)) cnt_i (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (gctl[0]),
      .wr_lo (bus_wr && bus_waddr == WA_CNT_LO),
      .wr_hi (bus_wr && bus_waddr == WA_CNT_HI),
      .wdata (bus_wdata),
      .cnt   (count)
   );

   generate
      for (genvar i = 0; i < N; i++) begin : g_bank
         assign tmr_wstb[i] = bus_wr && in_bank && (bank_idx == 5'(i));
         evt_timer_bank #(.MSG_CAP(MSG_CAP)) bank_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wstb     (tmr_wstb[i]),
            .woff     (bus_waddr[2:0]),
            .wdata    (bus_wdata),
            .rword    (bank_rd[i]),
            .cmp_ones (cmp_ones[i])
         );
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (in_bank) begin
         for (int i = 0; i < N; i++)
            if (bank_idx == 5'(i)) bus_rdata = bank_rd[i];
      end else begin
         case (bus_waddr)
            WA_CAP_LO:  bus_rdata = CAP_LO;
            WA_CAP_HI:  bus_rdata = TICK_FS;
            WA_GCTL_LO: bus_rdata = {30'd0, gctl};
            WA_CNT_LO:  bus_rdata = count[31:0];
            WA_CNT_HI:  bus_rdata = count[63:32];
            default:    bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/evt_regfile_chk.sv
module evt_regfile_chk #(
   parameter int N = 3
) (
   input logic         clk,
   input logic         rst_n,
   input logic [7:0]   bus_waddr,
   input logic         bus_wr,
   input logic [31:0]  bus_rdata,
   input logic [N-1:0] tmr_wstb,
   input logic [N-1:0] tmr_rearm,
   input logic         glb_en,
   input logic [63:0]  count
);
   logic cnt_wr;
   assign cnt_wr = bus_wr && (bus_waddr[7:1] == 7'h1E);

   // R5
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (glb_en && !cnt_wr) |=> (count == $past(count) + 64'd1));

   // R6
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!glb_en && !cnt_wr) |=> $stable(count));

   // R8
   rearm_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|tmr_rearm) |-> (glb_en && !$past(glb_en)));

   // R8
   rearm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|tmr_rearm) |=> (tmr_rearm == '0));

   // R9
   wstb_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tmr_wstb));

   // R11
   wstb_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|tmr_wstb) |-> bus_wr);

   // R2
   cap_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_waddr == 8'h01) |-> (bus_rdata == 32'd10_000_000));

   // R3
   gctl_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_waddr == 8'h05) |-> (bus_rdata == 32'd0));
endmodule

bind evt_regfile evt_regfile_chk #(.N(N)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_waddr (bus_waddr),
   .bus_wr    (bus_wr),
   .bus_rdata (bus_rdata),
   .tmr_wstb  (tmr_wstb),
   .tmr_rearm (tmr_rearm),
   .glb_en    (glb_en),
   .count     (count)
);

// File: tb/evt_regfile_tb_top.sv
`timescale 1ns/1ps
module evt_regfile_tb_top;
   localparam int N = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [7:0]   bus_waddr = '0;
   logic         bus_wr = 1'b0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic [N-1:0] tmr_wstb;
   logic [2:0]   tmr_woff;
   logic [N-1:0] tmr_rearm;
   logic         glb_en;
   logic [63:0]  count;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [31:0]  mdl [N][6];
   logic [N-1:0] last_wstb;
   logic [2:0]   last_woff;

   always #4 clk = ~clk;

   evt_regfile #(.N(N), .MSG_CAP(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_waddr(bus_waddr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_wstb(tmr_wstb),
      .tmr_woff(tmr_woff), .tmr_rearm(tmr_rearm), .glb_en(glb_en), .count(count)
   );

   function automatic logic [7:0] bw(int bank, int word);
      return 8'(8'h40 + bank * 8 + word);
   endfunction

   function automatic logic [31:0] cfg_model(logic [31:0] old, logic [31:0] d);
      return (old & ~32'h7F4E) | (d & 32'h7F4E);
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_waddr = a; bus_wdata = d; bus_wr = 1'b1;
      #1;
      last_wstb = tmr_wstb;
      last_woff = tmr_woff;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] v);
      bus_waddr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic check_bank(string req, int b);
      logic [31:0] v;
      for (int w = 0; w < 6; w++) begin
         rd(bw(b, w), v);
         check(req, 64'(v), 64'(mdl[b][w]));
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [63:0] held;
      logic [31:0] hi_b;
      void'($urandom(32'd20240611));
      for (int b = 0; b < N; b++) begin
         mdl[b][0] = 32'h30; mdl[b][1] = 32'h4;
         mdl[b][2] = '1;     mdl[b][3] = '1;
         mdl[b][4] = '0;     mdl[b][5] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 count", count, 64'd0);
      rd(8'h04, v); check("R1 gctl", 64'(v), 64'd0);
      for (int b = 0; b < N; b++) check_bank("R1 bank", b);

      // R2 capability and period, write ignored
      rd(8'h00, v); check("R2 cap_lo", 64'(v), 64'h8086_A201);
      rd(8'h01, v); check("R2 period", 64'(v), 64'h0098_9680);
      wr(8'h00, 32'h0); rd(8'h00, v); check("R2 cap_lo after write", 64'(v), 64'h8086_A201);

      // R3 only bits 1:0 kept; enable left clear
      wr(8'h04, 32'hFFFF_FFFE); rd(8'h04, v); check("R3 gctl", 64'(v), 64'h2);
      check("R3 glb_en", 64'(glb_en), 64'd0);
      wr(8'h05, 32'hFFFF_FFFF); rd(8'h05, v); check("R3 gctl_hi", 64'(v), 64'd0);
      wr(8'h04, 32'h0);

      // R7 halves while stopped
      wr(8'h3C, 32'h1234_5678); wr(8'h3D, 32'hCAFE_0001);
      check("R7 both halves", count, 64'hCAFE_0001_1234_5678);
      wr(8'h3C, 32'hFFFF_FFFE);
      check("R7 low only", count, 64'hCAFE_0001_FFFF_FFFE);
      wr(8'h3D, 32'h0);
      rd(8'h3D, v); check("R7 read high", 64'(v), 64'd0);

      // R8 prepare: channel 1 comparator no longer all ones
      wr(bw(1, 2), 32'h100); mdl[1][2] = 32'h100;

      // R5/R8 enable, carry across halves
      wr(8'h04, 32'h1);
      check("R6 no step on enabling edge", count, 64'h0000_0000_FFFF_FFFE);
      check("R8 rearm mask", 64'(tmr_rearm), 64'b010);
      @(negedge clk);
      check("R5 step", count, 64'h0000_0000_FFFF_FFFF);
      check("R8 rearm one cycle", 64'(tmr_rearm), 64'd0);
      @(negedge clk);
      check("R5 carry", count, 64'h0000_0001_0000_0000);

      // R6 freeze and resume
      wr(8'h04, 32'h0);
      held = count;
      repeat (4) @(negedge clk);
      check("R6 frozen", count, held);
      check("R8 no rearm on disable", 64'(tmr_rearm), 64'd0);
      wr(8'h04, 32'h1);
      check("R6 resume held", count, held);
      check("R8 rearm again", 64'(tmr_rearm), 64'b010);
      @(negedge clk);
      check("R6 resume step", count, held + 64'd1);

      // R7 half write while running wins over increment
      hi_b = count[63:32];
      wr(8'h3C, 32'h10);
      check("R7 running write", count, {hi_b, 32'h10});
      @(negedge clk);
      check("R7 continue", count, {hi_b, 32'h11});

      // R9 out-of-range bank
      wr(bw(N, 0), 32'hFFFF_FFFF);
      check("R9 no strobe", 64'(last_wstb), 64'd0);
      rd(bw(N, 2), v); check("R9 reads zero", 64'(v), 64'd0);
      rd(8'hFF, v); check("R9 window top", 64'(v), 64'd0);
      for (int b = 0; b < N; b++) check_bank("R9 banks untouched", b);

      // R10 holes
      rd(8'h02, v); check("R10 0x008", 64'(v), 64'd0);
      rd(8'h08, v); check("R10 0x020", 64'(v), 64'd0);
      rd(8'h3E, v); check("R10 0x0F8", 64'(v), 64'd0);
      rd(bw(0, 6), v); check("R10 bank +0x18", 64'(v), 64'd0);

      // R4/R11 random bank writes
      for (int k = 0; k < 60; k++) begin
         int b = int'($urandom % N);
         int w = int'($urandom % 6);
         logic [31:0] d = $urandom;
         wr(bw(b, w), d);
         check("R11 strobe", 64'(last_wstb), 64'(1 << b));
         check("R11 woff", 64'(last_woff), 64'(w));
         if (w == 0)      mdl[b][0] = cfg_model(mdl[b][0], d);
         else if (w != 1) mdl[b][w] = d;
         rd(bw(b, w), v);
         check((w < 2) ? "R4 cfg" : "R11 readback", 64'(v), 64'(mdl[b][w]));
      end
      // R4 directed: try to clear capability bits
      wr(bw(2, 0), 32'h0); mdl[2][0] = cfg_model(mdl[2][0], 32'h0);
      rd(bw(2, 0), v); check("R4 caps kept", 64'(v), 64'h30);
      wr(bw(2, 1), 32'h0);
      rd(bw(2, 1), v); check("R4 cfg_hi", 64'(v), 64'h4);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule